// File: doc/BRIEF.md
# Hybrid Dynamic-Static Branch Predictor

This block predicts branches for a scalar, single-issue pipeline. The fetch stage gives it the address of a branch, and decode gives it the branch's signed displacement. In the same cycle the block returns three things: whether the address hit in its target cache, the predicted direction, and the predicted next fetch address. The target cache is a direct-mapped table with 64 entries. Each entry holds a tag, a valid flag, a branch target and a two-bit saturating direction state. That state is a small four-state machine: it moves one step toward the real outcome each time the branch resolves.

When the address is not in the table, a static rule chooses the direction. A branch whose displacement is negative jumps backward, so it is treated as a loop and predicted taken. Any other branch is predicted not taken. The execute stage reports each resolved branch on a separate port. That report updates the matching entry, or it allocates a new entry if the branch missed and was taken.

The direction state machine has four states. SNT (code 00) is strongly not-taken, WNT (01) is weakly not-taken, WT (10) is weakly taken and ST (11) is strongly taken. Its transitions are:
- "strengthen" moves SNT→WNT→WT→ST on a taken outcome.
- "weaken" moves ST→WT→WNT→SNT on a not-taken outcome.
- "hold" keeps ST on taken and SNT on not-taken.
- "allocate" places a newly created entry in WT.

Top module: `bp_predictor`

## Requirements
- R1: A synchronous reset clears every valid flag. On the first cycle after reset, and on any cycle before a new allocation, pred_hit is 0 for every fetch address.
- R2: On a miss with a negative displacement (bit 23 of fetch_disp set), pred_taken is 1 and pred_target is fetch_pc plus the displacement sign-extended to 32 bits.
- R3: Whenever pred_taken is 0, pred_target is fetch_pc + 4. This holds for a miss with a non-negative displacement and for a hit whose state is 00 or 01.
- R4: On a hit, pred_taken is 1 for states 10 and 11 and 0 for states 00 and 01. A taken prediction returns the stored target. A taken resolve on an entry that hits replaces that stored target with res_target.
- R5: A taken resolve that misses allocates an entry in state WT (10) with res_target. From the next cycle, a lookup of that address hits and predicts taken to res_target.
- R6: A not-taken resolve that misses leaves the table unchanged. A later lookup of that address still misses.
- R7: Each resolve on a hitting entry moves its state one step toward the outcome, and the state saturates at 11 and at 00.
- R8: The table is indexed by pc[7:2] and tagged with pc[31:8]. An address with the same index but a different tag misses, and allocating it evicts the previous occupant.
- R9: When a lookup and an update touch the same entry in the same cycle, the lookup returns the contents from before the update. The new contents are visible from the next cycle.
- R10: On a hit, fetch_disp has no effect on the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 32 | Address of the branch being fetched |
| fetch_disp | input | 24 | Signed branch displacement from decode |
| pred_hit | output | 1 | Lookup hit a valid entry |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_target | input | 32 | Actual target of the resolved branch |

## Verification
The lookup and the resolve update can fall in the same cycle on the same table entry. The bench provokes this by driving fetch_pc and res_pc to the same address within one stimulus vector. It does so for a first allocation, for each counter step and for a target refresh. The check expects the prediction that the old contents give, and the vector that follows expects the new contents. Eviction is covered the same way: a resolve for a conflicting tag is reported while the old occupant is being looked up.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

endpackage

// File: rtl/bp_sat_fsm.sv
module bp_sat_fsm
    import bp_pkg::*;
(
    input  ctr_e cur_state,
    input  logic outcome_taken,
    output ctr_e next_state,
    output logic predict_taken
);

    // Transitions: strengthen on taken, weaken on not taken, hold at the ends.
    always_comb begin
        next_state = cur_state;
        unique case (cur_state)
            CTR_SNT: next_state = outcome_taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: next_state = outcome_taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  next_state = outcome_taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  next_state = outcome_taken ? CTR_ST  : CTR_WT;
            default: next_state = CTR_WT;
        endcase
    end

    always_comb begin
        unique case (cur_state)
            CTR_WT, CTR_ST:   predict_taken = 1'b1;
            CTR_SNT, CTR_WNT: predict_taken = 1'b0;
            default:          predict_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/bp_static.sv
module bp_static #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 24,
    parameter int STEP   = 4
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic              guess_taken,
    output logic [PC_W-1:0]   guess_target
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    always_comb begin
        disp_ext     = {{EXT_W{disp[DISP_W-1]}}, disp};
        guess_taken  = disp[DISP_W-1];
        guess_target = guess_taken ? (pc + disp_ext) : (pc + PC_W'(STEP));
    end

endmodule

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    output ctr_e             a_state,
    output logic [PC_W-1:0]  a_target,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    output ctr_e             b_state,
    output logic [PC_W-1:0]  b_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  ctr_e             wr_state,
    input  logic [PC_W-1:0]  wr_target
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    ctr_e               state_q  [ENTRIES];
    logic [PC_W-1:0]    target_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            state_q[wr_idx]  <= wr_state;
            target_q[wr_idx] <= wr_target;
        end
    end

    always_comb begin
        a_hit    = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
        a_state  = state_q[a_idx];
        a_target = target_q[a_idx];
        b_hit    = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
        b_state  = state_q[b_idx];
        b_target = target_q[b_idx];
    end

    // R1: nothing hits right after reset
    p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_hit && !b_hit));

    // R5: a written entry is visible on the next lookup of the same index and tag
    p_write_visible_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((a_idx != $past(wr_idx)) || (a_tag != $past(wr_tag)) || a_hit));

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int DISP_W  = 24,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [DISP_W-1:0] fetch_disp,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [PC_W-1:0]   pred_target,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [PC_W-1:0]   res_target
);

    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_W   = PC_W - TAG_LSB;
    localparam int STEP    = 1 << IDX_LSB;

    logic [IDX_W-1:0] f_idx, r_idx;
    logic [TAG_W-1:0] f_tag, r_tag;
    logic             f_hit, r_hit;
    ctr_e             f_state, r_state, r_next, wr_state;
    logic [PC_W-1:0]  f_target, r_old_target, wr_target;
    logic             f_dyn_taken, r_unused_dir;
    logic             s_taken;
    logic [PC_W-1:0]  s_target;
    logic             wr_en;

    assign f_idx = fetch_pc[TAG_LSB-1:IDX_LSB];
    assign f_tag = fetch_pc[PC_W-1:TAG_LSB];
    assign r_idx = res_pc[TAG_LSB-1:IDX_LSB];
    assign r_tag = res_pc[PC_W-1:TAG_LSB];

    bp_table #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .a_idx     (f_idx),
        .a_tag     (f_tag),
        .a_hit     (f_hit),
        .a_state   (f_state),
        .a_target  (f_target),
        .b_idx     (r_idx),
        .b_tag     (r_tag),
        .b_hit     (r_hit),
        .b_state   (r_state),
        .b_target  (r_old_target),
        .wr_en     (wr_en),
        .wr_idx    (r_idx),
        .wr_tag    (r_tag),
        .wr_state  (wr_state),
        .wr_target (wr_target)
    );

    bp_sat_fsm u_fetch_dir (
        .cur_state     (f_state),
        .outcome_taken (1'b0),
        .next_state    (),
        .predict_taken (f_dyn_taken)
    );

    bp_sat_fsm u_resolve_step (
        .cur_state     (r_state),
        .outcome_taken (res_taken),
        .next_state    (r_next),
        .predict_taken (r_unused_dir)
    );

    bp_static #(.PC_W(PC_W), .DISP_W(DISP_W), .STEP(STEP)) u_static (
        .pc           (fetch_pc),
        .disp         (fetch_disp),
        .guess_taken  (s_taken),
        .guess_target (s_target)
    );

    // Update path: step a hitting entry, allocate a taken miss in WT.
    always_comb begin
        wr_en     = res_valid && (r_hit || res_taken);
        wr_state  = r_hit ? r_next : CTR_WT;
        wr_target = res_taken ? res_target : r_old_target;
    end

    // Prediction path: dynamic on hit, static on miss.
    always_comb begin
        pred_hit = f_hit;
        if (f_hit) begin
            pred_taken  = f_dyn_taken;
            pred_target = f_dyn_taken ? f_target : (fetch_pc + PC_W'(STEP));
        end else begin
            pred_taken  = s_taken;
            pred_target = s_target;
        end
    end

    // R2: a miss follows the displacement sign
    p_static_dir_r2: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (pred_taken == fetch_disp[DISP_W-1]));

    // R3: a not-taken prediction falls through
    p_fallthru_r3: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> (pred_target == fetch_pc + PC_W'(STEP)));

    // R5: after a taken resolve the same address hits
    p_taken_alloc_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken) |=> ((fetch_pc != $past(res_pc)) || pred_hit));

    // R6: a not-taken resolve on a miss allocates nothing
    p_nt_no_alloc_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_taken && (res_pc == fetch_pc) && !pred_hit)
        |=> ((fetch_pc != $past(fetch_pc)) || !pred_hit));

endmodule

// File: tb/bp_predictor_bench.sv
module bp_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [7:0]  req;
        logic        rv;
        logic [31:0] rpc;
        logic        rt;
        logic [31:0] rtg;
        logic [31:0] fpc;
        logic [23:0] fd;
        logic        eh;
        logic        et;
        logic [31:0] etg;
    } vec_t;

    localparam logic [31:0] PA = 32'h0000_1040;
    localparam logic [31:0] PB = 32'h0000_2040;
    localparam logic [31:0] PC = 32'h0000_10FC;
    localparam logic [23:0] NEG40 = 24'hFFFFC0;
    localparam logic [23:0] FWD   = 24'h000100;
    localparam int NVEC = 27;

    localparam vec_t VECS [NVEC] = '{
        '{8'd1,  1'b0, 32'h0, 1'b0, 32'h0,        PA, 24'h0,  1'b0, 1'b0, PA + 4},          // R1 reset state
        '{8'd2,  1'b0, 32'h0, 1'b0, 32'h0,        PA, NEG40,  1'b0, 1'b1, 32'h0000_1000},   // R2 backward
        '{8'd3,  1'b0, 32'h0, 1'b0, 32'h0,        PA, FWD,    1'b0, 1'b0, PA + 4},          // R3 forward
        '{8'd6,  1'b1, PA,    1'b0, 32'h0,        PA, FWD,    1'b0, 1'b0, PA + 4},          // R6 nt resolve
        '{8'd6,  1'b0, 32'h0, 1'b0, 32'h0,        PA, FWD,    1'b0, 1'b0, PA + 4},          // R6 still miss
        '{8'd9,  1'b1, PA,    1'b1, 32'h0000_1000, PA, FWD,   1'b0, 1'b0, PA + 4},          // R9 old contents
        '{8'd5,  1'b0, 32'h0, 1'b0, 32'h0,        PA, FWD,    1'b1, 1'b1, 32'h0000_1000},   // R5 alloc WT, R10
        '{8'd7,  1'b1, PA,    1'b1, 32'h0000_1000, PA, FWD,   1'b1, 1'b1, 32'h0000_1000},   // R7 WT->ST
        '{8'd7,  1'b1, PA,    1'b1, 32'h0000_1000, PA, FWD,   1'b1, 1'b1, 32'h0000_1000},   // R7 ST hold
        '{8'd7,  1'b1, PA,    1'b0, 32'h0,        PA, FWD,    1'b1, 1'b1, 32'h0000_1000},   // R7 ST->WT
        '{8'd7,  1'b0, 32'h0, 1'b0, 32'h0,        PA, FWD,    1'b1, 1'b1, 32'h0000_1000},   // R7 WT
        '{8'd7,  1'b1, PA,    1'b0, 32'h0,        PA, FWD,    1'b1, 1'b1, 32'h0000_1000},   // R7 WT->WNT
        '{8'd10, 1'b0, 32'h0, 1'b0, 32'h0,        PA, NEG40,  1'b1, 1'b0, PA + 4},          // R10 disp ignored, R4
        '{8'd7,  1'b1, PA,    1'b0, 32'h0,        PA, FWD,    1'b1, 1'b0, PA + 4},          // R7 WNT->SNT
        '{8'd7,  1'b1, PA,    1'b0, 32'h0,        PA, FWD,    1'b1, 1'b0, PA + 4},          // R7 SNT hold
        '{8'd7,  1'b1, PA,    1'b1, 32'h0000_1000, PA, FWD,   1'b1, 1'b0, PA + 4},          // R7 SNT->WNT
        '{8'd7,  1'b0, 32'h0, 1'b0, 32'h0,        PA, FWD,    1'b1, 1'b0, PA + 4},          // R7 WNT
        '{8'd7,  1'b1, PA,    1'b1, 32'h0000_1000, PA, FWD,   1'b1, 1'b0, PA + 4},          // R7 WNT->WT
        '{8'd4,  1'b0, 32'h0, 1'b0, 32'h0,        PA, FWD,    1'b1, 1'b1, 32'h0000_1000},   // R4 WT taken
        '{8'd8,  1'b0, 32'h0, 1'b0, 32'h0,        PB, 24'h10, 1'b0, 1'b0, PB + 4},          // R8 tag mismatch
        '{8'd8,  1'b1, PB,    1'b1, 32'h0000_3000, PA, FWD,   1'b1, 1'b1, 32'h0000_1000},   // R8 evict, old seen
        '{8'd8,  1'b0, 32'h0, 1'b0, 32'h0,        PA, 24'h10, 1'b0, 1'b0, PA + 4},          // R8 evicted
        '{8'd8,  1'b0, 32'h0, 1'b0, 32'h0,        PB, FWD,    1'b1, 1'b1, 32'h0000_3000},   // R8 new occupant
        '{8'd4,  1'b1, PB,    1'b1, 32'h0000_3400, PB, FWD,   1'b1, 1'b1, 32'h0000_3000},   // R4 refresh, R9 old
        '{8'd4,  1'b0, 32'h0, 1'b0, 32'h0,        PB, FWD,    1'b1, 1'b1, 32'h0000_3400},   // R4 new target
        '{8'd2,  1'b0, 32'h0, 1'b0, 32'h0,        PC, 24'hFFFFFC, 1'b0, 1'b1, 32'h0000_10F8}, // R2 small
        '{8'd2,  1'b0, 32'h0, 1'b0, 32'h0,        PC, 24'h800000, 1'b0, 1'b1, 32'hFF80_10FC}  // R2 sign extension
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic [23:0] fetch_disp = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_target;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_predictor u_bp_predictor (
        .clk         (clk),
        .rst         (rst),
        .fetch_pc    (fetch_pc),
        .fetch_disp  (fetch_disp),
        .pred_hit    (pred_hit),
        .pred_taken  (pred_taken),
        .pred_target (pred_target),
        .res_valid   (res_valid),
        .res_pc      (res_pc),
        .res_taken   (res_taken),
        .res_target  (res_target)
    );

    task automatic check(input int req, input int tag, input logic eh, input logic et,
                         input logic [31:0] etg);
        n_checks++;
        if (pred_hit !== eh || pred_taken !== et || pred_target !== etg) begin
            n_fail++;
            $display("FAIL R%0d step %0d: got hit=%b taken=%b target=%h expected hit=%b taken=%b target=%h",
                     req, tag, pred_hit, pred_taken, pred_target, eh, et, etg);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            res_valid  = VECS[i].rv;
            res_pc     = VECS[i].rpc;
            res_taken  = VECS[i].rt;
            res_target = VECS[i].rtg;
            fetch_pc   = VECS[i].fpc;
            fetch_disp = VECS[i].fd;
            #1;
            check(int'(VECS[i].req), i, VECS[i].eh, VECS[i].et, VECS[i].etg);
            @(negedge clk);
        end
        res_valid = 1'b0;

        // R1: reset in mid-run drops every entry
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        fetch_pc = PB; fetch_disp = 24'h10;
        #1; check(1, 100, 1'b0, 1'b0, PB + 4);
        fetch_pc = PA; fetch_disp = NEG40;
        #1; check(1, 101, 1'b0, 1'b1, 32'h0000_1000);

        // R5: allocation then one not-taken weakens WT to WNT
        res_valid = 1'b1; res_pc = PC; res_taken = 1'b1; res_target = 32'h0000_0800;
        @(negedge clk);
        res_taken = 1'b0;
        fetch_pc = PC; fetch_disp = FWD;
        #1; check(5, 102, 1'b1, 1'b1, 32'h0000_0800);
        @(negedge clk);
        res_valid = 1'b0;
        #1; check(5, 103, 1'b1, 1'b0, PC + 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule